// File: doc/BRIEF.md
# Configuration-Header Bus Target

A 32-bit target for a single-function device on a shared, multiplexed address/data bus. In the address phase it classifies the four command/byte-enable lines. It answers configuration reads and writes when its select line is high. It also answers memory reads and writes that fall inside a 4 KB window placed by its one base address register. The memory window is backed by a small word store that aliases across the window.

The block holds a 64-byte configuration header with these contents:
- fixed identity words: vendor, device, class code and revision
- a command word with a memory-enable bit
- a miscellaneous word carrying self-test, header type, latency timer and cache line size
- the base address register
- an interrupt word with the pin number and a writable line number

Every claimed transaction carries exactly one data phase. The target raises its select and ready outputs one clock after the address phase and holds them until the initiator is ready. It generates even parity on the data it drives and checks the parity that initiators send with write data.

Top module: `pt_target`

## Requirements
- R1: After reset, devsel_o, trdy_o, ad_oe_o, par_oe_o and perr_o are low. The command word (dword 1) reads 0, the base register (dword 4) reads 0 with PREFETCH at bit 3, dword 3 reads {BIST_CAP,7'b0,24'h0} and dword 15 reads 0x00000100.
- R2: A configuration cycle is claimed only when three conditions hold in the address phase: the command is 1010 (read) or 1011 (write), idsel_i is high, and ad_i[1:0] is 00. ad_i[7:2] selects the dword. Any other configuration attempt is not claimed and changes nothing.
- R3: For a claimed cycle, devsel_o and trdy_o rise in the clock after the address phase. They stay high through wait states in which irdy_i is low. They fall in the clock after the first data phase in which irdy_i is high. Only one data phase is taken. ad_o is driven (ad_oe_o high) only during a claimed read data phase.
- R4: Dword 0 reads {DEVICE_ID,VENDOR_ID}. Dword 2 reads {CLASS_CODE,REVISION}. Header type (dword 3 bits 23:16) reads 0x00, meaning single function. Interrupt pin (dword 15 bits 15:8) reads 1. Dwords 5 to 14 and 16 to 63 read 0.
- R5: Identity words, class code, revision, header type, self-test capability and interrupt pin ignore writes.
- R6: These fields are writable: command bit 1 (memory enable), latency timer (dword 3 bits 15:8), cache line size (dword 3 bits 7:0) and interrupt line (dword 15 bits 3:0). During the data phase cbe_i is an active-low byte-enable mask. A byte whose cbe_i bit is 1 keeps its old value.
- R7: Base register bit 0 and bits 2:1 read 0, meaning memory anywhere in 32-bit space. Bit 3 reads PREFETCH. Only bits 31:12 are writable, so writing all ones reads back 0xFFFFF000 (PREFETCH 0).
- R8: Memory commands 0110, 1100 and 1110 read, and 0111 and 1111 write. They are claimed only when command bit 1 is set and ad_i[31:12] equals the base register bits 31:12. Written data, merged by byte enables, reads back. Commands 0000, 0001, 0010, 0011 and 1101 are never claimed.
- R9: Self-test byte bit 7 reads BIST_CAP. Writing 1 to bit 6 starts a self-test that finishes within a clock. Later reads show bit 6 at 0 and completion code bits 3:0 at 0 (pass).
- R10: In the clock after each cycle with ad_oe_o high, par_oe_o is high and par_o equals the XOR of that cycle's ad_o and cbe_i (even parity).
- R11: In a claimed write, par_i sampled in the clock after the data transfer is compared with the XOR of the transferred ad_i and cbe_i. A mismatch raises perr_o for one clock, in the following clock.
- R12: A device built with VENDOR_ID 0xFFFF (absent) never raises devsel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_i | input | 1 | High in the address phase and while more data follows |
| irdy_i | input | 1 | Initiator ready for the data phase |
| idsel_i | input | 1 | Configuration select |
| ad_i | input | 32 | Address/data from the bus |
| cbe_i | input | 4 | Command in address phase, active-low byte enables in data phase |
| par_i | input | 1 | Even parity from the initiator, one clock behind its data |
| ad_o | output | 32 | Read data |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| par_o | output | 1 | Even parity over driven data and byte enables |
| par_oe_o | output | 1 | Drive enable for par_o |
| devsel_o | output | 1 | Target has claimed the cycle |
| trdy_o | output | 1 | Target ready for the data phase |
| perr_o | output | 1 | Data parity error on a received write |

## Verification
The bench probes the limits of the configuration select. Missing idsel_i, a nonzero ad_i[1:0], and a write with the select low must all leave the target silent and the header unchanged. A decoder that ignored either condition would claim these cycles or corrupt the interrupt line. It writes all ones over the read-only identity words and over a byte mask that straddles the header-type byte, then reads the base register back after an all-ones write. A design that let writes through would show changed IDs, a nonzero header type, or low address bits set in the size answer. Memory cycles are tried before enabling, outside the window, and with I/O, special, acknowledge and dual-address commands; a loose decoder would assert devsel_o on them. Wait states, a partial byte-enable store, a deliberately wrong write parity and an absent-device copy on the same bus expose sloppy hold timing, lane merging, parity offset and phantom claims.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [3:0] {
        CMD_INTACK  = 4'b0000,
        CMD_SPECIAL = 4'b0001,
        CMD_IORD    = 4'b0010,
        CMD_IOWR    = 4'b0011,
        CMD_MEMRD   = 4'b0110,
        CMD_MEMWR   = 4'b0111,
        CMD_CFGRD   = 4'b1010,
        CMD_CFGWR   = 4'b1011,
        CMD_MEMRDM  = 4'b1100,
        CMD_DUAL    = 4'b1101,
        CMD_MEMRDL  = 4'b1110,
        CMD_MEMWI   = 4'b1111
    } bus_cmd_e;

    typedef struct packed {
        logic is_cfg;
        logic is_mem;
        logic is_write;
    } cmd_class_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_WAIT = 2'd2
    } bus_st_e;

    function automatic cmd_class_t classify(input logic [3:0] code);
        cmd_class_t c;
        c = '0;
        case (code)
            CMD_CFGRD:  c.is_cfg = 1'b1;
            CMD_CFGWR:  begin c.is_cfg = 1'b1; c.is_write = 1'b1; end
            CMD_MEMRD, CMD_MEMRDM, CMD_MEMRDL: c.is_mem = 1'b1;
            CMD_MEMWR, CMD_MEMWI: begin c.is_mem = 1'b1; c.is_write = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be_n);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be_n[b] ? old_v[8*b +: 8] : new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pt_cfg_space.sv
module pt_cfg_space
    import pt_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID  = 16'hB17E,
    parameter logic [23:0] CLASS_CODE = 24'h058000,
    parameter logic [7:0]  REVISION   = 8'h03,
    parameter bit          BIST_CAP   = 1'b1,
    parameter bit          PREFETCH   = 1'b0,
    parameter int          WIN_BITS   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [5:0]          rd_idx,
    output logic [31:0]         rd_data,
    input  logic                wr_en,
    input  logic [5:0]          wr_idx,
    input  logic [31:0]         wr_data,
    input  logic [3:0]          wr_be_n,
    output logic                mem_en,
    output logic [31-WIN_BITS:0] bar_base
);
    localparam int BARW = 32 - WIN_BITS;

    typedef struct packed {
        logic            mem_en;
        logic [7:0]      latency;
        logic [7:0]      line_size;
        logic [3:0]      int_line;
        logic [BARW-1:0] base;
        logic            bist_run;
    } cfg_t;

    cfg_t q, d;
    logic [31:0] v_id, v_cmd, v_class, v_misc, v_bar, v_int, w;

    assign v_id    = {DEVICE_ID, VENDOR_ID};
    assign v_cmd   = {30'b0, q.mem_en, 1'b0};
    assign v_class = {CLASS_CODE, REVISION};
    assign v_misc  = {BIST_CAP, q.bist_run, 6'b0, 8'h00, q.latency, q.line_size};
    assign v_bar   = {q.base, {(WIN_BITS-4){1'b0}}, PREFETCH, 3'b000};
    assign v_int   = {16'h0000, 8'h01, 4'h0, q.int_line};

    always_comb begin
        case (rd_idx)
            6'd0:    rd_data = v_id;
            6'd1:    rd_data = v_cmd;
            6'd2:    rd_data = v_class;
            6'd3:    rd_data = v_misc;
            6'd4:    rd_data = v_bar;
            6'd15:   rd_data = v_int;
            default: rd_data = 32'h0;
        endcase
    end

    always_comb begin
        d = q;
        d.bist_run = 1'b0;
        w = 32'h0;
        if (wr_en) begin
            case (wr_idx)
                6'd1: begin
                    w = lane_merge(v_cmd, wr_data, wr_be_n);
                    d.mem_en = w[1];
                end
                6'd3: begin
                    w = lane_merge(v_misc, wr_data, wr_be_n);
                    d.latency   = w[15:8];
                    d.line_size = w[7:0];
                    d.bist_run  = BIST_CAP && w[30] && !wr_be_n[3];
                end
                6'd4: begin
                    w = lane_merge(v_bar, wr_data, wr_be_n);
                    d.base = w[31:WIN_BITS];
                end
                6'd15: begin
                    w = lane_merge(v_int, wr_data, wr_be_n);
                    d.int_line = w[3:0];
                end
                default: w = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_en   = q.mem_en;
    assign bar_base = q.base;

    assert_bist_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.bist_run |=> !q.bist_run);

    assert_bar_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.base) |-> $past(wr_en && wr_idx == 6'd4));

endmodule

// File: rtl/pt_mem_window.sv
module pt_mem_window #(
    parameter int WORDS = 16,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic [IW-1:0] idx,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic [3:0]    wr_be_n,
    output logic [31:0]   rd_data
);
    logic [31:0] mem_q [WORDS];

    assign rd_data = mem_q[idx];

    always_ff @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (wr_en && !wr_be_n[b]) mem_q[idx][8*b +: 8] <= wr_data[8*b +: 8];
        end
    end
endmodule

// File: rtl/pt_parity.sv
module pt_parity (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [35:0] drv_bits,
    input  logic        drv_en,
    input  logic [35:0] chk_bits,
    input  logic        chk_en,
    input  logic        par_i,
    output logic        par_o,
    output logic        par_oe_o,
    output logic        perr_o
);
    typedef struct packed {
        logic par;
        logic par_oe;
        logic pend;
        logic expect_par;
        logic perr;
    } par_t;

    par_t q, d;

    always_comb begin
        d            = q;
        d.par        = ^drv_bits;
        d.par_oe     = drv_en;
        d.pend       = chk_en;
        d.expect_par = ^chk_bits;
        d.perr       = q.pend && (par_i != q.expect_par);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign par_o    = q.par;
    assign par_oe_o = q.par_oe;
    assign perr_o   = q.perr;

    assert_perr_after_check_R11: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(q.pend));

    assert_par_follows_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> $past(drv_en));
endmodule

// File: rtl/pt_target.sv
module pt_target
    import pt_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID  = 16'hB17E,
    parameter logic [23:0] CLASS_CODE = 24'h058000,
    parameter logic [7:0]  REVISION   = 8'h03,
    parameter bit          BIST_CAP   = 1'b1,
    parameter bit          PREFETCH   = 1'b0,
    parameter int          WIN_BITS   = 12,
    parameter int          MEM_WORDS  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_i,
    input  logic        irdy_i,
    input  logic        idsel_i,
    input  logic [31:0] ad_i,
    input  logic [3:0]  cbe_i,
    input  logic        par_i,
    output logic [31:0] ad_o,
    output logic        ad_oe_o,
    output logic        par_o,
    output logic        par_oe_o,
    output logic        devsel_o,
    output logic        trdy_o,
    output logic        perr_o
);
    localparam int  IW     = $clog2(MEM_WORDS);
    localparam bit  ABSENT = (VENDOR_ID == 16'hFFFF);

    typedef struct packed {
        bus_st_e     st;
        logic        devsel;
        logic        trdy;
        logic        write;
        logic        cfg;
        logic [5:0]  idx;
        logic [31:0] rdata;
    } tgt_t;

    tgt_t q, d;

    cmd_class_t          cls;
    logic                cfg_hit, mem_hit, xfer, mem_en;
    logic [31-WIN_BITS:0] bar_base;
    logic [31:0]         cfg_rd, mem_rd;
    logic [IW-1:0]       mem_idx;

    assign cls     = classify(cbe_i);
    assign cfg_hit = !ABSENT && cls.is_cfg && idsel_i && (ad_i[1:0] == 2'b00);
    assign mem_hit = !ABSENT && cls.is_mem && mem_en && (ad_i[31:WIN_BITS] == bar_base);
    assign xfer    = (q.st == ST_DATA) && irdy_i;
    assign mem_idx = (q.st == ST_IDLE) ? ad_i[2 +: IW] : q.idx[IW-1:0];

    pt_cfg_space #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
        .REVISION(REVISION), .BIST_CAP(BIST_CAP), .PREFETCH(PREFETCH),
        .WIN_BITS(WIN_BITS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ad_i[7:2]), .rd_data(cfg_rd),
        .wr_en(xfer && q.write && q.cfg), .wr_idx(q.idx),
        .wr_data(ad_i), .wr_be_n(cbe_i),
        .mem_en(mem_en), .bar_base(bar_base)
    );

    pt_mem_window #(.WORDS(MEM_WORDS)) u_mem (
        .clk(clk), .idx(mem_idx),
        .wr_en(xfer && q.write && !q.cfg),
        .wr_data(ad_i), .wr_be_n(cbe_i), .rd_data(mem_rd)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (frame_i) begin
                    if (cfg_hit || mem_hit) begin
                        d.st     = ST_DATA;
                        d.devsel = 1'b1;
                        d.trdy   = 1'b1;
                        d.write  = cls.is_write;
                        d.cfg    = cfg_hit;
                        d.idx    = ad_i[7:2];
                        d.rdata  = cfg_hit ? cfg_rd : mem_rd;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_DATA: begin
                if (irdy_i) begin
                    d.st     = ST_WAIT;
                    d.devsel = 1'b0;
                    d.trdy   = 1'b0;
                end
            end
            default: begin
                if (!frame_i && !irdy_i) d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign devsel_o = q.devsel;
    assign trdy_o   = q.trdy;
    assign ad_oe_o  = (q.st == ST_DATA) && !q.write;
    assign ad_o     = q.rdata;

    pt_parity u_par (
        .clk(clk), .rst_n(rst_n),
        .drv_bits({ad_o, cbe_i}), .drv_en(ad_oe_o),
        .chk_bits({ad_i, cbe_i}), .chk_en(xfer && q.write),
        .par_i(par_i), .par_o(par_o), .par_oe_o(par_oe_o), .perr_o(perr_o)
    );

    assert_devsel_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_o) |-> $past(frame_i && q.st == ST_IDLE));

    assert_cfg_needs_idsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(devsel_o) && q.cfg) |-> $past(idsel_i));

    assert_mem_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(devsel_o) && !q.cfg) |-> $past(mem_en));

    assert_drive_when_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> (devsel_o && trdy_o));
endmodule

// File: tb/pt_target_test.sv
`timescale 1ns/1ps
module pt_target_test;
    localparam logic [15:0] VEN = 16'h1D0F;
    localparam logic [15:0] DEV = 16'hB17E;
    localparam logic [23:0] CLS = 24'h058000;
    localparam logic [7:0]  REV = 8'h03;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frame = 0, irdy = 0, idsel = 0, par_in = 0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = 4'hF;
    logic [31:0] ad_o, ab_ad;
    logic ad_oe, par_o, par_oe, devsel, trdy, perr;
    logic ab_oe, ab_par, ab_paroe, ab_devsel, ab_trdy, ab_perr;

    int checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    pt_target #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_CODE(CLS), .REVISION(REV),
                .BIST_CAP(1'b1), .PREFETCH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .irdy_i(irdy), .idsel_i(idsel),
        .ad_i(ad), .cbe_i(cbe), .par_i(par_in), .ad_o(ad_o), .ad_oe_o(ad_oe),
        .par_o(par_o), .par_oe_o(par_oe), .devsel_o(devsel), .trdy_o(trdy), .perr_o(perr));

    pt_target #(.VENDOR_ID(16'hFFFF)) absent_dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .irdy_i(irdy), .idsel_i(idsel),
        .ad_i(ad), .cbe_i(cbe), .par_i(par_in), .ad_o(ab_ad), .ad_oe_o(ab_oe),
        .par_o(ab_par), .par_oe_o(ab_paroe), .devsel_o(ab_devsel), .trdy_o(ab_trdy),
        .perr_o(ab_perr));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops an expected word at every read transfer
    always @(negedge clk) begin
        if (rst_n && ad_oe && trdy && irdy) begin
            if (exp_q.size() == 0) check(1'b0, "R8 unexpected read", ad_o, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ad_o == e, t, ad_o, e);
            end
        end
    end

    task automatic bus(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                       input logic [31:0] wdata, input logic [3:0] be_n,
                       input logic claim, input logic [31:0] exp_rd,
                       input logic bad_par, input int waits, input string req);
        logic wr;
        wr = cmd[0];
        if (claim && !wr) begin exp_q.push_back(exp_rd); tag_q.push_back(req); end
        @(posedge clk); #1;
        frame = 1; ad = addr; cbe = cmd; idsel = sel;
        @(posedge clk); #1;
        frame = 0; idsel = 0; cbe = be_n; ad = wr ? wdata : 32'h0; irdy = (waits == 0);
        @(negedge clk);
        check(devsel == claim && trdy == claim, {req, " R3 claim"}, {30'b0, devsel, trdy},
              {30'b0, claim, claim});
        check(ab_devsel == 1'b0, "R12 absent device claimed", {31'b0, ab_devsel}, 32'h0);
        for (int i = 0; i < waits; i++) begin
            @(posedge clk); #1;
            irdy = (i == waits - 1);
            @(negedge clk);
            check(devsel == claim, "R3 hold in wait state", {31'b0, devsel}, {31'b0, claim});
        end
        @(posedge clk); #1;
        irdy = 0; cbe = 4'hF; ad = 32'h0;
        par_in = (^{wdata, be_n}) ^ bad_par;
        @(negedge clk);
        check(devsel == 1'b0 && trdy == 1'b0, "R3 release", {30'b0, devsel, trdy}, 32'h0);
        if (claim && !wr)
            check(par_oe && par_o == ^{exp_rd, be_n}, "R10 read parity",
                  {30'b0, par_oe, par_o}, {30'b0, 1'b1, ^{exp_rd, be_n}});
        @(posedge clk); #1;
        par_in = 0;
        @(negedge clk);
        check(perr == (claim && wr && bad_par), "R11 parity error flag", {31'b0, perr},
              {31'b0, claim && wr && bad_par});
    endtask

    function automatic logic [31:0] ca(input int idx);
        return 32'(idx) << 2;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({devsel, trdy, ad_oe, par_oe, perr} == 5'b0, "R1 outputs at reset",
              {27'b0, devsel, trdy, ad_oe, par_oe, perr}, 32'h0);
        #1 rst_n = 1;
        // R1 reset contents
        bus(4'b1010, ca(1), 1, 0, 4'h0, 1, 32'h0000_0000, 0, 0, "R1 command word");
        bus(4'b1010, ca(4), 1, 0, 4'h0, 1, 32'h0000_0000, 0, 0, "R1 base register");
        bus(4'b1010, ca(15), 1, 0, 4'h0, 1, 32'h0000_0100, 0, 0, "R1 interrupt word");
        bus(4'b1010, ca(3), 1, 0, 4'h0, 1, 32'h8000_0000, 0, 0, "R9 self-test capable");
        // R4 header contents
        bus(4'b1010, ca(0), 1, 0, 4'h0, 1, {DEV, VEN}, 0, 0, "R4 identity");
        bus(4'b1010, ca(2), 1, 0, 4'h0, 1, {CLS, REV}, 0, 0, "R4 class");
        bus(4'b1010, ca(7), 1, 0, 4'h0, 1, 32'h0, 0, 0, "R4 unimplemented dword");
        // R2 select qualification
        bus(4'b1010, ca(0), 0, 0, 4'h0, 0, 0, 0, 0, "R2 no idsel");
        bus(4'b1010, ca(0) | 32'h1, 1, 0, 4'h0, 0, 0, 0, 0, "R2 low bits nonzero");
        // R5 read-only
        bus(4'b1011, ca(0), 1, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, 0, "R5 write id");
        bus(4'b1010, ca(0), 1, 0, 4'h0, 1, {DEV, VEN}, 0, 0, "R5 identity kept");
        bus(4'b1011, ca(2), 1, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, 0, "R5 write class");
        bus(4'b1010, ca(2), 1, 0, 4'h0, 1, {CLS, REV}, 0, 0, "R5 class kept");
        // R6 and R9 misc word
        bus(4'b1011, ca(3), 1, 32'h4000_2010, 4'h0, 1, 0, 0, 0, "R9 start self-test");
        bus(4'b1010, ca(3), 1, 0, 4'h0, 1, 32'h8000_2010, 0, 0, "R9 R6 misc after start");
        bus(4'b1011, ca(3), 1, 32'h0000_0008, 4'b1110, 1, 0, 0, 0, "R6 byte0 write");
        bus(4'b1010, ca(3), 1, 0, 4'h0, 1, 32'h8000_2008, 0, 0, "R6 byte merge");
        bus(4'b1011, ca(3), 1, 32'h00FF_FF00, 4'b1001, 1, 0, 0, 0, "R5 header byte write");
        bus(4'b1010, ca(3), 1, 0, 4'h0, 1, 32'h8000_FF08, 0, 0, "R5 R6 header type kept");
        bus(4'b1011, ca(15), 1, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, 0, "R6 int line write");
        bus(4'b1010, ca(15), 1, 0, 4'h0, 1, 32'h0000_010F, 0, 0, "R6 int line and pin");
        bus(4'b1011, ca(15), 0, 32'h0, 4'h0, 0, 0, 0, 0, "R2 write without idsel");
        bus(4'b1010, ca(15), 1, 0, 4'h0, 1, 32'h0000_010F, 0, 0, "R2 write ignored");
        // R7 base register
        bus(4'b1011, ca(4), 1, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, 0, "R7 size probe");
        bus(4'b1010, ca(4), 1, 0, 4'h0, 1, 32'hFFFF_F000, 0, 0, "R7 size answer");
        bus(4'b1011, ca(4), 1, 32'h1234_5ABC, 4'h0, 1, 0, 0, 0, "R7 program base");
        bus(4'b1010, ca(4), 1, 0, 4'h0, 1, 32'h1234_5000, 0, 0, "R7 base readback");
        // R8 memory
        bus(4'b0110, 32'h1234_5000, 0, 0, 4'h0, 0, 0, 0, 0, "R8 disabled");
        bus(4'b1011, ca(1), 1, 32'hFFFF_FFFF, 4'h0, 1, 0, 0, 0, "R6 enable memory");
        bus(4'b1010, ca(1), 1, 0, 4'h0, 1, 32'h0000_0002, 0, 0, "R6 command readback");
        bus(4'b0111, 32'h1234_5004, 0, 32'hA5A5_0001, 4'h0, 1, 0, 0, 0, "R8 mem write");
        bus(4'b0110, 32'h1234_5004, 0, 0, 4'h0, 1, 32'hA5A5_0001, 0, 2, "R8 R3 mem read waits");
        bus(4'b1111, 32'h1234_5FF8, 0, 32'hDEAD_BEEF, 4'h0, 1, 0, 1, 0, "R11 bad parity write");
        bus(4'b1110, 32'h1234_5FF8, 0, 0, 4'h0, 1, 32'hDEAD_BEEF, 0, 0, "R8 read line");
        bus(4'b0111, 32'h1234_5004, 0, 32'h0000_7777, 4'b1100, 1, 0, 0, 0, "R8 partial write");
        bus(4'b1100, 32'h1234_5004, 0, 0, 4'b0000, 1, 32'hA5A5_7777, 0, 0, "R8 read multiple");
        bus(4'b0110, 32'h1234_6004, 0, 0, 4'h0, 0, 0, 0, 0, "R8 window miss");
        bus(4'b0010, 32'h1234_5004, 1, 0, 4'h0, 0, 0, 0, 0, "R8 io read");
        bus(4'b0011, 32'h1234_5004, 1, 32'h1, 4'h0, 0, 0, 0, 0, "R8 io write");
        bus(4'b0001, 32'h1234_5004, 1, 32'h1, 4'h0, 0, 0, 0, 0, "R8 special");
        bus(4'b0000, 32'h1234_5004, 1, 0, 4'h0, 0, 0, 0, 0, "R8 intack");
        bus(4'b1101, 32'h1234_5004, 1, 32'h1, 4'h0, 0, 0, 0, 0, "R8 dual address");
        bus(4'b1011, ca(1), 1, 32'h0, 4'h0, 1, 0, 0, 0, "R8 disable memory");
        bus(4'b0110, 32'h1234_5004, 0, 0, 4'h0, 0, 0, 0, 0, "R8 after disable");
        check(exp_q.size() == 0, "R3 reads outstanding", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule